// File: doc/BRIEF.md
# Single-Shot SAR Conversion Controller

This block runs one successive-approximation conversion on one converter unit each time software asks for it. Software places a one-hot channel mask, a packed table of 2-bit attenuation settings, a resolution code and an invert bit on the configuration inputs. It then raises the start input from 0 to 1. The controller powers the converter up and holds it in reset for a programmed wait. A start wait and a programmed sampling window follow. The controller then resolves one result bit per divided clock tick. At the end it latches the result and raises a done flag.

After a conversion the converter stays powered for a programmed standby time, then powers down. A new request that arrives during standby starts a new conversion without first dropping power. All waits are counted in ticks of an internal clock divider. The divider restarts at each launch, so the conversion latency is exact. The analog side is outside the block. It receives the power, reset and sample controls, the channel mask, the attenuation and the trial code. It answers with one comparator bit, which is 1 when the input is at or above the trial code.

Top module: `sar_oneshot_ctrl`

## Requirements
- R1: While reset is applied and after it is released, busy, done, ana_pwr, ana_rst and ana_sample are 0 and result is 0.
- R2: A conversion is launched only by a 0-to-1 transition of start_req while pad_mask has exactly one bit set. A zero mask or a mask with several bits set, and a start_req held high, launch nothing: busy stays 0 and done and result keep their values.
- R3: A 0-to-1 transition of start_req while busy is 1 is ignored. The running conversion keeps its timing and its result.
- R4: Let D = clk_div (0 counts as 1) and let W(x) = x (0 counts as 1). The launch is the clock edge that samples the start rise. After it, ana_rst is high for D*W(rst_wait) cycles and ana_sample is high for D*W(sample_cyc) cycles. Done rises D*(W(rst_wait)+W(start_wait)+W(sample_cyc)+N) cycles after the launch, where N is the number of resolved bits.
- R5: res_code values 0, 1, 2 and 3 select N = 9, 10, 11 and 12 bits. The result is the N-bit successive-approximation value (the top N bits of the 12-bit input level), right-aligned in result, with the upper bits zero.
- R6: With data_inv = 1 at completion, the N result bits are complemented and the upper bits stay zero.
- R7: While ana_pwr is 1, ana_pad equals the launched one-hot mask and ana_atten equals the launched channel c's field, bits [2c+1:2c] of atten_packed. While ana_pwr is 0, ana_pad is 0.
- R8: The launch clears done. Result keeps its previous value until the edge on which the next conversion completes.
- R9: After done rises, ana_pwr stays high for D*W(standby_wait) cycles and then falls. A launch during this standby keeps ana_pwr high throughout.
- R10: Busy is 1 from the launch edge until the edge on which done rises. Busy and done are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Conversion request; its rising edge launches a conversion |
| pad_mask | input | NCH | One-hot channel select |
| atten_packed | input | 2*NCH | 2-bit attenuation per channel, channel c at bit 2c |
| res_code | input | 2 | Resolution: 0..3 for 9..12 bits |
| data_inv | input | 1 | Complement the result |
| clk_div | input | DIVW | Tick divider (0 acts as 1) |
| rst_wait | input | WAITW | Converter reset wait, in ticks |
| start_wait | input | WAITW | Wait after reset, in ticks |
| sample_cyc | input | 3 | Sampling window, in ticks |
| standby_wait | input | WAITW | Powered idle time after done, in ticks |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Result valid |
| result | output | DW | Latched conversion result |
| ana_pwr | output | 1 | Converter power enable |
| ana_rst | output | 1 | Converter reset |
| ana_sample | output | 1 | Sampling window |
| ana_pad | output | NCH | Active channel mask |
| ana_atten | output | 2 | Active attenuation |
| ana_code | output | DW | Trial code during bit resolution |
| ana_cmp | input | 1 | Comparator answer: input at or above ana_code |

## Verification
Conversions are run with distinct input levels on several channels, so that each resolution code shows which low bits are dropped, and with the invert bit set, which separates complementing the N bits from complementing the whole word. Divider values of 0, 1, 2, 4 and 16, together with zero and nonzero waits, show through the exact done latency and the reset and sample window lengths whether each wait is counted in ticks and whether zero is clamped. Zero and multi-bit masks, a start held high, and a second start rise during a conversion confirm that only a clean edge on an idle unit with one selected channel launches anything. Back-to-back requests within standby show that power is kept on.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RSTW = 3'd1,
    S_STW  = 3'd2,
    S_SAMP = 3'd3,
    S_CONV = 3'd4,
    S_STBY = 3'd5
  } seq_st_e;

  localparam int DEF_DIV        = 16;
  localparam int DEF_RST_WAIT   = 8;
  localparam int DEF_START_WAIT = 16;
  localparam int DEF_SAMPLE     = 2;
  localparam int DEF_STANDBY    = 100;
endpackage

// File: rtl/sar_tick_div.sv
module sar_tick_div #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = (div == '0) ? '0 : div - 1'b1;
    tick  = (cnt_q >= lim);
    cnt_d = (clr || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          launch,
  input  logic [CW-1:0] rst_wait,
  input  logic [CW-1:0] start_wait,
  input  logic [2:0]    sample_cyc,
  input  logic [CW-1:0] standby_wait,
  input  logic [CW-1:0] nbits,
  output seq_st_e       st,
  output logic          conv_step,
  output logic          conv_last
);
  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic [CW:0]   cnt_inc;
  logic          span_end;

  always_comb begin
    case (st_q)
      S_RSTW:  lim = rst_wait;
      S_STW:   lim = start_wait;
      S_SAMP:  lim = CW'(sample_cyc);
      S_CONV:  lim = nbits;
      S_STBY:  lim = standby_wait;
      default: lim = '0;
    endcase
    cnt_inc  = {1'b0, cnt_q} + 1'b1;
    span_end = (cnt_inc >= {1'b0, lim});
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (launch) begin
      st_d  = S_RSTW;
      cnt_d = '0;
    end else if (tick && st_q != S_IDLE) begin
      if (span_end) begin
        cnt_d = '0;
        case (st_q)
          S_RSTW:  st_d = S_STW;
          S_STW:   st_d = S_SAMP;
          S_SAMP:  st_d = S_CONV;
          S_CONV:  st_d = S_STBY;
          default: st_d = S_IDLE;
        endcase
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st        = st_q;
  assign conv_step = tick && !launch && (st_q == S_CONV);
  assign conv_last = conv_step && span_end;
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          conv_step,
  input  logic          cmp,
  output logic [DW-1:0] trial,
  output logic [DW-1:0] acc_nxt
);
  logic [DW-1:0] acc_q, bit_q;

  always_comb begin
    trial   = acc_q | bit_q;
    acc_nxt = cmp ? trial : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      bit_q <= '0;
    end else if (launch) begin
      acc_q <= '0;
      bit_q <= {1'b1, {(DW-1){1'b0}}};
    end else if (conv_step) begin
      acc_q <= acc_nxt;
      bit_q <= {1'b0, bit_q[DW-1:1]};
    end
  end
endmodule

// File: rtl/sar_oneshot_ctrl.sv
module sar_oneshot_ctrl
  import sar_pkg::*;
#(
  parameter int NCH   = 10,
  parameter int DW    = 12,
  parameter int DIVW  = 8,
  parameter int WAITW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [NCH-1:0]    pad_mask,
  input  logic [2*NCH-1:0]  atten_packed,
  input  logic [1:0]        res_code,
  input  logic              data_inv,
  input  logic [DIVW-1:0]   clk_div,
  input  logic [WAITW-1:0]  rst_wait,
  input  logic [WAITW-1:0]  start_wait,
  input  logic [2:0]        sample_cyc,
  input  logic [WAITW-1:0]  standby_wait,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     result,
  output logic              ana_pwr,
  output logic              ana_rst,
  output logic              ana_sample,
  output logic [NCH-1:0]    ana_pad,
  output logic [1:0]        ana_atten,
  output logic [DW-1:0]     ana_code,
  input  logic              ana_cmp
);
  localparam int MINB = DW - 3;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  // channel attenuation pick, one slice per channel
  logic [1:0] fld [NCH];
  logic [1:0] atten_sel;
  for (genvar i = 0; i < NCH; i++) begin : g_fld
    assign fld[i] = pad_mask[i] ? atten_packed[2*i +: 2] : 2'b00;
  end
  always_comb begin
    atten_sel = 2'b00;
    for (int i = 0; i < NCH; i++) atten_sel = atten_sel | fld[i];
  end

  seq_st_e          st;
  logic             start_q, tick, launch, conv_step, conv_last, mask_ok;
  logic [NCH-1:0]   pad_q;
  logic [1:0]       atten_q;
  logic [WAITW-1:0] nb_q, nb_d;
  logic             done_q, done_d;
  logic [DW-1:0]    res_q, res_d, trial, acc_nxt, raw, fmask;

  always_comb begin
    mask_ok = (pad_mask != '0) && ((pad_mask & (pad_mask - 1'b1)) == '0);
    busy    = (st == S_RSTW) || (st == S_STW) || (st == S_SAMP) || (st == S_CONV);
    launch  = start_req && !start_q && !busy && mask_ok;
    nb_d    = WAITW'(MINB) + WAITW'(res_code);
    raw     = acc_nxt >> (DW - int'(nb_q));
    fmask   = {DW{1'b1}} >> (DW - int'(nb_q));
    res_d   = data_inv ? (~raw & fmask) : raw;
    done_d  = launch ? 1'b0 : (conv_last ? 1'b1 : done_q);
  end

  sar_tick_div #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_n_s), .clr(launch), .div(clk_div), .tick(tick)
  );

  sar_seq #(.CW(WAITW)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .launch(launch),
    .rst_wait(rst_wait), .start_wait(start_wait), .sample_cyc(sample_cyc),
    .standby_wait(standby_wait), .nbits(nb_q),
    .st(st), .conv_step(conv_step), .conv_last(conv_last)
  );

  sar_approx #(.DW(DW)) u_sar (
    .clk(clk), .rst_n(rst_n_s), .launch(launch), .conv_step(conv_step),
    .cmp(ana_cmp), .trial(trial), .acc_nxt(acc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= start_req;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pad_q   <= '0;
      atten_q <= '0;
      nb_q    <= WAITW'(DW);
    end else if (launch) begin
      pad_q   <= pad_mask;
      atten_q <= atten_sel;
      nb_q    <= nb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)       res_q <= '0;
    else if (conv_last) res_q <= res_d;
  end

  assign done       = done_q;
  assign result     = res_q;
  assign ana_pwr    = (st != S_IDLE);
  assign ana_rst    = (st == S_RSTW);
  assign ana_sample = (st == S_SAMP);
  assign ana_pad    = ana_pwr ? pad_q : '0;
  assign ana_atten  = atten_q;
  assign ana_code   = (st == S_CONV) ? trial : '0;
endmodule

// File: rtl/sar_oneshot_chk.sv
module sar_oneshot_chk #(
  parameter int NCH = 10,
  parameter int DW  = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_req,
  input logic           busy,
  input logic           done,
  input logic [DW-1:0]  result,
  input logic           ana_pwr,
  input logic           ana_rst,
  input logic           ana_sample,
  input logic [NCH-1:0] ana_pad
);
  a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> $stable(result));
  a_r7_pad_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    ana_pwr |-> $onehot(ana_pad));
  a_r7_pad_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ana_pwr |-> (ana_pad == '0));
  a_r4_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ana_rst && ana_sample));
  a_r4_phase_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ana_rst || ana_sample) |-> (busy && ana_pwr));
  a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req));
  a_r9_pwr_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ana_pwr) |-> !busy);
endmodule

bind sar_oneshot_ctrl sar_oneshot_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .busy(busy), .done(done),
  .result(result), .ana_pwr(ana_pwr), .ana_rst(ana_rst),
  .ana_sample(ana_sample), .ana_pad(ana_pad)
);

// File: tb/sar_oneshot_ctrl_tb_top.sv
module sar_oneshot_ctrl_tb_top;
  import sar_pkg::*;
  localparam int NCH = 10;
  localparam int DW  = 12;

  logic              clk, rst_n, start_req, data_inv, busy, done;
  logic              ana_pwr, ana_rst, ana_sample, ana_cmp;
  logic [NCH-1:0]    pad_mask, ana_pad;
  logic [2*NCH-1:0]  atten_packed;
  logic [1:0]        res_code, ana_atten;
  logic [7:0]        clk_div, rst_wait, start_wait, standby_wait;
  logic [2:0]        sample_cyc;
  logic [DW-1:0]     result, ana_code;
  logic [DW-1:0]     vin [NCH];
  int nchk, nerr;

  sar_oneshot_ctrl #(.NCH(NCH), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .pad_mask(pad_mask),
    .atten_packed(atten_packed), .res_code(res_code), .data_inv(data_inv),
    .clk_div(clk_div), .rst_wait(rst_wait), .start_wait(start_wait),
    .sample_cyc(sample_cyc), .standby_wait(standby_wait), .busy(busy),
    .done(done), .result(result), .ana_pwr(ana_pwr), .ana_rst(ana_rst),
    .ana_sample(ana_sample), .ana_pad(ana_pad), .ana_atten(ana_atten),
    .ana_code(ana_code), .ana_cmp(ana_cmp)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural converter: compares the selected input level with the trial code
  always_comb begin
    ana_cmp = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (ana_pad[c]) ana_cmp = (vin[c] >= ana_code);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int w1(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  // one conversion; poke > 0 re-raises start while busy
  task automatic run_conv(input int ch, input int res, input bit inv, input int div,
                          input int rw, input int sw, input int sp, input int sb,
                          input int poke);
    int d, n, t, k, erst, esmp, exp_res, prev_res, rst_cnt, smp_cnt, pwr_low;
    d = w1(div);
    n = 9 + res;
    t = d * (w1(rw) + w1(sw) + w1(sp) + n);
    exp_res = int'(vin[ch]) >> (12 - n);
    if (inv) exp_res = (~exp_res) & ((1 << n) - 1);
    @(negedge clk);
    pad_mask = NCH'(1) << ch; res_code = 2'(res); data_inv = inv;
    clk_div = 8'(div); rst_wait = 8'(rw); start_wait = 8'(sw);
    sample_cyc = 3'(sp); standby_wait = 8'(sb); start_req = 1'b0;
    @(negedge clk);
    prev_res = int'(result);
    start_req = 1'b1;
    @(posedge clk); #1;
    check(busy == 1'b1, "R10 busy at launch", busy, 1);
    check(done == 1'b0, "R8 done cleared at launch", done, 0);
    check(ana_pad == (NCH'(1) << ch), "R7 pad mask", int'(ana_pad), 1 << ch);
    check(ana_atten == atten_packed[2*ch +: 2], "R7 attenuation",
          int'(ana_atten), int'(atten_packed[2*ch +: 2]));
    rst_cnt = int'(ana_rst); smp_cnt = int'(ana_sample); pwr_low = 0;
    k = 0;
    for (int i = 1; i < t + 40; i++) begin
      @(posedge clk); #1;
      k = i;
      if (done) break;
      if (result != DW'(prev_res)) pwr_low += 1000;
      rst_cnt += int'(ana_rst);
      smp_cnt += int'(ana_sample);
      if (!ana_pwr || !busy) pwr_low++;
      if (i == poke) start_req = 1'b0;
      if (i == poke + 1) start_req = 1'b1;
    end
    erst = d * w1(rw);
    esmp = d * w1(sp);
    check(k == t, "R4 done latency", k, t);
    check(rst_cnt == erst, "R4 reset window", rst_cnt, erst);
    check(smp_cnt == esmp, "R4 sample window", smp_cnt, esmp);
    check(int'(result) == exp_res, inv ? "R6 inverted result" : "R5 result",
          int'(result), exp_res);
    check(busy == 1'b0, "R10 busy low at done", busy, 0);
    check(pwr_low == 0, "R8 R9 R10 hold during conversion", pwr_low, 0);
  endtask

  task automatic standby_check(input int div, input int sb);
    int cnt, e;
    cnt = 0;
    e = w1(div) * w1(sb) - 1;
    for (int i = 0; i < e + 40; i++) begin
      @(posedge clk); #1;
      if (!ana_pwr) break;
      cnt++;
    end
    check(cnt == e, "R9 standby length", cnt, e);
    check(done == 1'b1, "R8 done kept after power-down", done, 1);
  endtask

  task automatic ignore_start(input logic [NCH-1:0] m);
    logic [DW-1:0] r0;
    logic d0;
    int bad;
    @(negedge clk);
    pad_mask = m; start_req = 1'b0;
    @(negedge clk);
    r0 = result; d0 = done; start_req = 1'b1;
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (busy || ana_pwr) bad++;
    end
    check(bad == 0, "R2 bad mask no launch", bad, 0);
    check(done == d0 && result == r0, "R2 bad mask state kept", int'(result), int'(r0));
  endtask

  task automatic held_high(input int cycles);
    int bad;
    bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      if (!done || busy) bad++;
    end
    check(bad == 0, "R2 held start no relaunch", bad, 0);
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    nchk = 0; nerr = 0;
    for (int c = 0; c < NCH; c++) begin
      vin[c] = DW'(12'hA5C ^ (c * 12'h137));
      atten_packed[2*c +: 2] = 2'((c * 3 + 1) % 4);
    end
    rst_n = 1'b0; start_req = 1'b0; pad_mask = '0; res_code = 2'd3;
    data_inv = 1'b0; clk_div = 8'd1; rst_wait = 8'd2; start_wait = 8'd1;
    sample_cyc = 3'd2; standby_wait = 8'd2;
    repeat (3) @(posedge clk);
    #1;
    check(!busy && !done && !ana_pwr && !ana_rst && !ana_sample && result == '0,
          "R1 in reset", int'(result), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(!busy && !done && !ana_pwr && result == '0, "R1 after reset", int'(busy), 0);

    run_conv(3, 3, 1'b0, 1, 2, 1, 2, 2, 0);   // R5 12 bits
    run_conv(0, 0, 1'b0, 1, 3, 2, 1, 2, 0);   // R5 9 bits
    run_conv(5, 1, 1'b0, 1, 1, 1, 7, 2, 0);   // R5 10 bits
    run_conv(9, 2, 1'b0, 1, 2, 3, 3, 2, 0);   // R5 11 bits
    run_conv(7, 1, 1'b1, 1, 2, 1, 2, 2, 0);   // R6 invert
    run_conv(2, 3, 1'b1, 1, 2, 1, 2, 2, 0);   // R6 invert full width
    run_conv(4, 3, 1'b0, 4, 3, 2, 3, 2, 0);   // R4 divider 4
    run_conv(6, 2, 1'b0, 0, 0, 0, 0, 0, 0);   // R4 zero clamps
    run_conv(8, 3, 1'b0, 1, 4, 2, 2, 2, 5);   // R3 start rise while busy
    held_high(20);                            // R2 held start
    run_conv(1, 3, 1'b0, 2, 2, 1, 2, 5, 0);
    standby_check(2, 5);                      // R9
    ignore_start('0);                         // R2 zero mask
    ignore_start(NCH'(10'b0000100100));       // R2 two bits set
    run_conv(3, 0, 1'b0, 1, 2, 1, 2, 50, 0);
    run_conv(5, 3, 1'b0, 1, 2, 1, 2, 50, 0);  // R9 relaunch in standby
    run_conv(9, 3, 1'b0, DEF_DIV, DEF_RST_WAIT, DEF_START_WAIT, DEF_SAMPLE, 3, 0);
    standby_check(DEF_DIV, 3);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule